// File: doc/BRIEF.md
# Toggle-Feedback Event Synchronizer

This block moves single events from an asynchronous strobe into a destination clock domain. Every rising edge of the strobe that the block accepts becomes exactly one destination-clock-wide pulse, no matter how fast or slow the strobe is compared with the destination clock. The strobe itself clocks a toggle flop. The destination clock samples that flop through a short flop chain. An XOR between the last synchronizer flop and one detector flop forms the pulse.

The toggle flop loads the inverse of the second destination flop. It therefore changes only after the previous change has come back through that flop. Any strobe edge that arrives while an event is still in flight is discarded, so the block never loses count of what it delivers. An optional return path, clocked by the strobe, reports on the source side when an event has landed. The synchronizer depth is a parameter, and the third flop is for very short destination periods.

Top module: `event_pulse_xing`

## Requirements
- R1: While `rst_n` is low, every flop is cleared to 0, so `dst_pulse` and `src_ack` are 0. After release, no `dst_pulse` appears until a strobe rising edge is accepted.
- R2: Each accepted rising edge of `ev_strobe` yields exactly one `dst_pulse`. A rising edge is accepted when the second destination flop already equals the source toggle at that edge.
- R3: `dst_pulse` is high for exactly one `dst_clk` cycle and is never high in two consecutive cycles.
- R4: With `DST_DEPTH`=2, a strobe edge that lands between two `dst_clk` rising edges drives `dst_pulse` high after the second following `dst_clk` edge and low after the third.
- R5: A strobe rising edge that comes before the previous toggle has reached the second destination flop is dropped. It toggles nothing and never produces a pulse. Edges spaced one destination cycle apart are therefore accepted only every other time.
- R6: After a dropped burst, the next strobe edge that follows the crossing of the accepted event is accepted and produces one pulse.
- R7: With `ACK_EN`=1, `src_ack` is examined at each strobe rising edge. If the second destination flop differs from the value captured at the previous strobe edge, `src_ack` goes high after this edge. It stays high until the next strobe rising edge, so it is exactly one strobe interval wide.
- R8: With `ACK_EN`=0, `src_ack` stays at 0.
- R9: `DST_DEPTH`=3 adds one synchronizer flop, which delays `dst_pulse` by exactly one more `dst_clk` cycle than in R4. The feedback still comes from the second destination flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ev_strobe | input | 1 | Asynchronous event strobe; each rising edge is a candidate event and clocks the source flops |
| dst_clk | input | 1 | Destination clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| dst_pulse | output | 1 | One-cycle pulse in the `dst_clk` domain per accepted event |
| src_ack | output | 1 | Source-side delivery notice, one strobe interval wide |

## Verification
The embedded properties check, at every relevant edge, four things. The pulse is one cycle wide. No pulse comes out of the first destination cycle after reset. The toggle holds whenever an earlier event is still in flight. The toggle moves only when the feedback has caught up. Only the directed scenarios can show the actual latency in destination cycles, the exact number of pulses produced by bursts and trains, the dropping pattern at one-cycle spacing, and the acknowledge timing relative to strobe edges. Each of these depends on the phase between the strobe and the destination clock, which the bench controls.

// File: rtl/epx_pkg.sv
`timescale 1ns/100ps
package epx_pkg;
    // index of the destination flop fed back to the source toggle
    localparam int unsigned EPX_FB_STAGE  = 1;
    // fewest synchronizer flops allowed ahead of the detector
    localparam int unsigned EPX_MIN_DEPTH = 2;

    typedef struct packed {
        logic tog;
    } src_state_t;

    typedef struct packed {
        logic seen;
        logic pulse;
    } ack_state_t;
endpackage

// File: rtl/epx_src_toggle.sv
`timescale 1ns/100ps
module epx_src_toggle
    import epx_pkg::*;
(
    input  logic strobe,
    input  logic rst_n,
    input  logic fb_sync,
    output logic tog
);
    src_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.tog = ~fb_sync;
    end

    always_ff @(posedge strobe or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tog = st_q.tog;

    // an edge while the previous toggle is still in flight leaves the toggle alone
    assert_hold_when_busy_R5: assert property (@(posedge strobe) disable iff (!rst_n)
        (st_q.tog != fb_sync) |=> $stable(st_q.tog));

    // a change of the toggle only follows an edge where the feedback had caught up
    assert_accept_on_caught_up_R2: assert property (@(posedge strobe) disable iff (!rst_n)
        (st_q.tog != $past(st_q.tog)) |-> ($past(st_q.tog) == $past(fb_sync)));
endmodule

// File: rtl/epx_dst_sync.sv
`timescale 1ns/100ps
module epx_dst_sync
    import epx_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_async,
    output logic fb_sync,
    output logic pulse
);
    localparam int unsigned DEPTH_EFF = (DEPTH < EPX_MIN_DEPTH) ? EPX_MIN_DEPTH : DEPTH;
    localparam int unsigned LAST      = DEPTH_EFF - 1;

    typedef struct packed {
        logic [DEPTH_EFF-1:0] chain;
        logic                 det;
    } dst_state_t;

    dst_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = tog_async;
        for (int i = 1; i < int'(DEPTH_EFF); i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.det = st_q.chain[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fb_sync = st_q.chain[EPX_FB_STAGE];
    assign pulse   = st_q.chain[LAST] ^ st_q.det;

    // checker-only flag: low during the first destination cycle after reset
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |=> !pulse);

    assert_single_cycle_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/epx_src_ack.sv
`timescale 1ns/100ps
module epx_src_ack
    import epx_pkg::*;
(
    input  logic strobe,
    input  logic rst_n,
    input  logic fb_sync,
    output logic ack
);
    ack_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.seen  = fb_sync;
        st_d.pulse = fb_sync ^ st_q.seen;
    end

    always_ff @(posedge strobe or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack = st_q.pulse;
endmodule

// File: rtl/event_pulse_xing.sv
`timescale 1ns/100ps
module event_pulse_xing
    import epx_pkg::*;
#(
    parameter int unsigned DST_DEPTH = 2,
    parameter bit          ACK_EN    = 1'b1
) (
    input  logic ev_strobe,
    input  logic dst_clk,
    input  logic rst_n,
    output logic dst_pulse,
    output logic src_ack
);
    logic tog;
    logic fb_sync;

    epx_src_toggle u_src (
        .strobe  (ev_strobe),
        .rst_n   (rst_n),
        .fb_sync (fb_sync),
        .tog     (tog)
    );

    epx_dst_sync #(.DEPTH(DST_DEPTH)) u_dst (
        .clk       (dst_clk),
        .rst_n     (rst_n),
        .tog_async (tog),
        .fb_sync   (fb_sync),
        .pulse     (dst_pulse)
    );

    generate
        if (ACK_EN) begin : g_ack
            epx_src_ack u_ack (
                .strobe  (ev_strobe),
                .rst_n   (rst_n),
                .fb_sync (fb_sync),
                .ack     (src_ack)
            );
        end else begin : g_no_ack
            assign src_ack = 1'b0;
        end
    endgenerate
endmodule

// File: tb/event_pulse_xing_tb.sv
`timescale 1ns/100ps
module event_pulse_xing_tb;
    localparam int CLK_PERIOD = 10;

    logic dst_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic strobe  = 1'b0;
    logic pulse2, ack2, pulse3, ack3;

    int total = 0;
    int bad   = 0;
    int cnt2  = 0;
    int cnt3  = 0;
    int wide2 = 0;
    int wide3 = 0;
    logic prev2 = 1'b0;
    logic prev3 = 1'b0;

    event_pulse_xing u_dut (
        .ev_strobe (strobe), .dst_clk (dst_clk), .rst_n (rst_n),
        .dst_pulse (pulse2), .src_ack (ack2)
    );

    event_pulse_xing #(.DST_DEPTH(3), .ACK_EN(1'b0)) u_dut3 (
        .ev_strobe (strobe), .dst_clk (dst_clk), .rst_n (rst_n),
        .dst_pulse (pulse3), .src_ack (ack3)
    );

    always #(CLK_PERIOD/2) dst_clk = ~dst_clk;

    always @(negedge dst_clk) begin
        cnt2 += int'(pulse2);
        cnt3 += int'(pulse3);
        if (pulse2 && prev2) wide2++;
        if (pulse3 && prev3) wide3++;
        prev2 = pulse2;
        prev3 = pulse3;
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fire();
        strobe = 1'b1;
        #0.4;
        strobe = 1'b0;
        #0.4;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge dst_clk);
    endtask

    task automatic t_reset();
        wait_cycles(2);
        check("R1 pulse in reset", int'(pulse2), 0);
        check("R1 ack in reset", int'(ack2), 0);
        check("R1 depth3 pulse in reset", int'(pulse3), 0);
        @(negedge dst_clk) rst_n = 1'b1;
        wait_cycles(6);
        check("R1 no pulse after release", cnt2, 0);
        check("R1 no pulse after release depth3", cnt3, 0);
    endtask

    task automatic t_latency();
        int c2 = cnt2;
        int c3 = cnt3;
        @(negedge dst_clk); #1; fire();
        @(negedge dst_clk);
        check("R4 low after first edge", int'(pulse2), 0);
        check("R9 low after first edge", int'(pulse3), 0);
        @(negedge dst_clk);
        check("R4 high after second edge", int'(pulse2), 1);
        check("R9 low after second edge", int'(pulse3), 0);
        @(negedge dst_clk);
        check("R4 low after third edge", int'(pulse2), 0);
        check("R9 high after third edge", int'(pulse3), 1);
        @(negedge dst_clk);
        check("R9 low after fourth edge", int'(pulse3), 0);
        wait_cycles(4);
        check("R2 one pulse per event", cnt2 - c2, 1);
        check("R2 one pulse per event depth3", cnt3 - c3, 1);
    endtask

    task automatic t_burst();
        int c2 = cnt2;
        int c3 = cnt3;
        @(negedge dst_clk); #1;
        repeat (4) fire();
        wait_cycles(8);
        check("R5 burst gives one pulse", cnt2 - c2, 1);
        check("R5 burst gives one pulse depth3", cnt3 - c3, 1);
        c2 = cnt2;
        c3 = cnt3;
        @(negedge dst_clk); #1; fire();
        wait_cycles(8);
        check("R6 next edge accepted", cnt2 - c2, 1);
        check("R6 next edge accepted depth3", cnt3 - c3, 1);
    endtask

    task automatic t_one_cycle_spacing();
        int c2 = cnt2;
        int c3 = cnt3;
        for (int k = 0; k < 6; k++) begin
            @(negedge dst_clk); #1; fire();
        end
        wait_cycles(8);
        check("R5 every other edge kept", cnt2 - c2, 3);
        check("R5 every other edge kept depth3", cnt3 - c3, 3);
    endtask

    task automatic t_train();
        int c2 = cnt2;
        int c3 = cnt3;
        for (int k = 0; k < 6; k++) begin
            @(negedge dst_clk); #1; fire();
            wait_cycles(6);
        end
        wait_cycles(4);
        check("R2 spaced train", cnt2 - c2, 6);
        check("R2 spaced train depth3", cnt3 - c3, 6);
        check("R3 no wide pulse", wide2, 0);
        check("R3 no wide pulse depth3", wide3, 0);
    endtask

    task automatic t_ack();
        int c2 = cnt2;
        @(negedge dst_clk); #1; fire();
        wait_cycles(8);
        @(negedge dst_clk); #1; fire();
        check("R7 ack after delivered event", int'(ack2), 1);
        check("R8 ack disabled", int'(ack3), 0);
        fire();
        check("R7 ack one strobe interval", int'(ack2), 0);
        wait_cycles(8);
        @(negedge dst_clk); #1; fire();
        check("R7 ack for probe event", int'(ack2), 1);
        check("R8 ack disabled later", int'(ack3), 0);
        wait_cycles(8);
        check("R5 ack scenario pulse count", cnt2 - c2, 3);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_burst();
        t_one_cycle_spacing();
        t_train();
        t_ack();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        total++;
        bad++;
        $display("FAIL watchdog all requirements actual=timeout expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule